// File: doc/BRIEF.md
# Right-Justified TDM Audio Serial Transmitter

This block takes stereo PCM samples through a load handshake and shifts them out on one serial data line. It runs as a slave to an external bit clock and an external word clock, and both clocks are sampled in the block's system clock domain. Each channel's bits are aligned to the end of that channel's word-clock half, most significant bit first. The left channel uses the half in which the word clock is high, and a frame starts at the rising edge of the word clock. The word length can be selected. A start offset, counted in bit clocks, can move the slot earlier, away from the closing word-clock edge. The active edge of the bit clock can be inverted.

Outside its own slot the transmitter can release the line: the output-enable drops and the data bit reads 0. Several transmitters with different offsets can therefore share one line as a time-division multiplexed bus. The block does not know the half length in advance. It measures the number of bit clocks between word-clock edges and uses that count to predict the closing edge of each half, so the first bit of a half can be launched before that edge is seen.

The controlling state machine has four states:
- TRK_IDLE: powered down.
- TRK_SYNC: waiting for a word-clock edge.
- TRK_MEASURE: counting one complete half.
- TRK_RUN: driving the line.

Its transitions are:
- TRK_IDLE → TRK_SYNC when enabled.
- TRK_SYNC → TRK_MEASURE on the first word-clock change seen at a capture edge.
- TRK_MEASURE → TRK_RUN on the next word-clock change.
- Every state → TRK_IDLE when the enable is low.
- TRK_RUN stays in TRK_RUN and takes a fresh half length at every word-clock change.

Top module: `rj_tdm_tx`

## Requirements
- R1: After reset, sdata_oe and sdata are 0, smp_ready is 1 and cfg_invalid is 0.
- R2: cfg_wlen selects the word length W: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. The slot carries bits W-1 down to 0 of the 32-bit sample.
- R3: With offset 0, a channel's bits are sent MSB first. Its LSB is the bit present on the last capture edge of its word-clock half.
- R4: The left sample occupies the half in which wclk is high, the right sample occupies the half in which wclk is low, and a frame starts at the rising edge of wclk.
- R5: With cfg_tristate set, every bit outside the slot has sdata_oe at 0 and sdata at 0.
- R6: With offset F, bit b of a channel is present on capture edge H-1-F-b of its half, where H is the half length in bit clocks. Bits that would fall before the start of the half are not sent.
- R7: With cfg_tristate clear, sdata_oe is 1 on every bit of both halves while running, and sdata is 0 outside the slot.
- R8: With cfg_bclk_inv at 0, data changes after a falling bclk edge and is valid at the rising edge. With cfg_bclk_inv at 1, the roles of the two edges are swapped.
- R9: A sample pair accepted during a frame is first sent in the next frame. The current frame finishes with the pair it started with.
- R10: smp_ready is 1 only while the holding register is empty. A pair is taken when smp_valid and smp_ready are both high. smp_ready stays 0, and smp_valid is ignored, until the pair moves to the output at the next frame start.
- R11: While running, if the half length is shorter than W (one frame is less than 2W bit clocks), cfg_invalid is 1 and sdata_oe is 0 on every bit.
- R12: While en is 0, sdata_oe is 0 from the next clock on.
- R13: Apart from power-down, sdata and sdata_oe change only in the clock after a launch edge of bclk, so they stay constant across the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Power enable of the serial interface |
| bclk | input | 1 | Bit clock, sampled by clk |
| wclk | input | 1 | Word clock; high marks the left half |
| cfg_wlen | input | 2 | Word length code |
| cfg_offset | input | OFF_W | Slot offset from the closing word-clock edge, in bit clocks |
| cfg_bclk_inv | input | 1 | Swap the launch and capture edges of bclk |
| cfg_tristate | input | 1 | Release the line outside the slot |
| smp_left | input | 32 | Left sample, right-aligned |
| smp_right | input | 32 | Right sample, right-aligned |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding register empty |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the data line |
| cfg_invalid | output | 1 | Frame too short for the word length |

## Verification
The bench checks every bit of each frame against a model that places bit H-1-F-k of the current pair at capture k. It does this for several combinations:
- different word lengths (16, 20, 24 and 32 bits)
- half lengths of 16 and 32
- offsets of 0, 5 and 4, where offset 4 with 32-bit words drops the top bits
- the tristate mode switched on and off

Together these tell apart a slot that is aligned to the start of the half rather than the end, a slot with the wrong width, and idle bits that are released when they should be driven, or the reverse. Other runs cover further cases:
- A mid-frame load plus a rejected second offer shows whether a sample is taken immediately or held until the frame boundary.
- An inverted bit clock, a too-short half and a power-down show whether the launch edge, the invalid flag and the forced release act at the right time.

// File: rtl/rj_tdm_pkg.sv
package rj_tdm_pkg;

    localparam int SAMPLE_W = 32;

    typedef enum logic [1:0] {
        TRK_IDLE    = 2'd0,
        TRK_SYNC    = 2'd1,
        TRK_MEASURE = 2'd2,
        TRK_RUN     = 2'd3
    } trk_state_e;

    // word length code to number of bits
    function automatic logic [5:0] wlen_bits(input logic [1:0] code);
        logic [5:0] n;
        unique case (code)
            2'd0: n = 6'd16;
            2'd1: n = 6'd20;
            2'd2: n = 6'd24;
            2'd3: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rj_tdm_frame_trk.sv
module rj_tdm_frame_trk
    import rj_tdm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bclk,
    input  logic             invert,
    input  logic             wclk,
    output logic             launch_evt,
    output logic             run,
    output logic [CNT_W-1:0] nidx,
    output logic             next_left,
    output logic [CNT_W-1:0] half_len
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    trk_state_e       state, state_nx;
    logic             bclk_q;
    logic             wclk_cap;
    logic [CNT_W-1:0] pos;
    logic             rise, fall, capture_evt, wclk_chg, wrap;

    assign rise        = bclk & ~bclk_q;
    assign fall        = ~bclk & bclk_q;
    assign capture_evt = invert ? fall : rise;
    assign launch_evt  = invert ? rise : fall;
    assign wclk_chg    = capture_evt && (wclk != wclk_cap);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TRK_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = TRK_IDLE;
        end else begin
            unique case (state)
                TRK_IDLE:    state_nx = TRK_SYNC;
                TRK_SYNC:    if (wclk_chg) state_nx = TRK_MEASURE;
                TRK_MEASURE: if (wclk_chg) state_nx = TRK_RUN;
                TRK_RUN:     state_nx = TRK_RUN;
            endcase
        end
    end

    // bit position inside the current half and measured half length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q   <= 1'b0;
            wclk_cap <= 1'b0;
            pos      <= '0;
            half_len <= '0;
        end else begin
            bclk_q <= bclk;
            if (capture_evt) begin
                wclk_cap <= wclk;
                if (wclk != wclk_cap) begin
                    pos <= '0;
                    if (state == TRK_MEASURE || state == TRK_RUN)
                        half_len <= pos + ONE;
                end else if (pos != '1) begin
                    pos <= pos + ONE;
                end
            end
        end
    end

    // outputs: which position the next launched bit belongs to
    always_comb begin
        run       = (state == TRK_RUN);
        wrap      = (pos == half_len - ONE);
        nidx      = wrap ? '0 : pos + ONE;
        next_left = wrap ? ~wclk_cap : wclk_cap;
    end

    // R12: power-down sends the tracker back to idle
    assert_idle_on_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == TRK_IDLE));

    // R11: running always implies a measured half length
    assert_run_measured_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_RUN) |-> (half_len != '0));

endmodule

// File: rtl/rj_tdm_smp_buf.sv
module rj_tdm_smp_buf #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_l,
    input  logic [DW-1:0] in_r,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          xfer,
    output logic [DW-1:0] frame_l,
    output logic [DW-1:0] frame_r
);

    logic [DW-1:0] pend_l, pend_r, act_l, act_r;
    logic          full;
    logic          take;

    assign in_ready = ~full;
    assign take     = in_valid & ~full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_l <= '0;
            pend_r <= '0;
            act_l  <= '0;
            act_r  <= '0;
            full   <= 1'b0;
        end else if (take) begin
            pend_l <= in_l;
            pend_r <= in_r;
            full   <= 1'b1;
        end else if (xfer && full) begin
            act_l <= pend_l;
            act_r <= pend_r;
            full  <= 1'b0;
        end
    end

    // the bit launched at a frame start already uses the new pair
    always_comb begin
        frame_l = (xfer && full) ? pend_l : act_l;
        frame_r = (xfer && full) ? pend_r : act_r;
    end

    // R10: a held pair stays until the frame start moves it
    assert_hold_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !xfer) |=> (full && $stable(pend_l) && $stable(pend_r)));

endmodule

// File: rtl/rj_tdm_tx.sv
module rj_tdm_tx
    import rj_tdm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int OFF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                bclk,
    input  logic                wclk,
    input  logic [1:0]          cfg_wlen,
    input  logic [OFF_W-1:0]    cfg_offset,
    input  logic                cfg_bclk_inv,
    input  logic                cfg_tristate,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                smp_valid,
    output logic                smp_ready,
    output logic                sdata,
    output logic                sdata_oe,
    output logic                cfg_invalid
);

    localparam int               IDX_W = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic                launch_evt, run, next_left;
    logic [CNT_W-1:0]    nidx, half_len;
    logic [SAMPLE_W-1:0] frame_l, frame_r, sel_word;
    logic [CNT_W-1:0]    wl, off_ext, tail, bpos;
    logic                frame_start, in_slot, bit_val;

    rj_tdm_frame_trk #(.CNT_W(CNT_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .bclk       (bclk),
        .invert     (cfg_bclk_inv),
        .wclk       (wclk),
        .launch_evt (launch_evt),
        .run        (run),
        .nidx       (nidx),
        .next_left  (next_left),
        .half_len   (half_len)
    );

    assign frame_start = launch_evt && run && (nidx == '0) && next_left;

    rj_tdm_smp_buf #(.DW(SAMPLE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_l     (smp_left),
        .in_r     (smp_right),
        .in_valid (smp_valid),
        .in_ready (smp_ready),
        .xfer     (frame_start),
        .frame_l  (frame_l),
        .frame_r  (frame_r)
    );

    // slot placement: bit index = half_len-1-offset-position
    always_comb begin
        wl          = {{(CNT_W-6){1'b0}}, wlen_bits(cfg_wlen)};
        off_ext     = {{(CNT_W-OFF_W){1'b0}}, cfg_offset};
        tail        = half_len - ONE - nidx;
        bpos        = tail - off_ext;
        in_slot     = (nidx < half_len) && (tail >= off_ext) && (bpos < wl);
        sel_word    = next_left ? frame_l : frame_r;
        bit_val     = sel_word[bpos[IDX_W-1:0]];
        cfg_invalid = run && (half_len < wl);
    end

    // line driver: updates only at launch edges, forced off at power-down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata    <= 1'b0;
            sdata_oe <= 1'b0;
        end else if (!en) begin
            sdata    <= 1'b0;
            sdata_oe <= 1'b0;
        end else if (launch_evt) begin
            if (run && !cfg_invalid) begin
                sdata_oe <= cfg_tristate ? in_slot : 1'b1;
                sdata    <= in_slot & bit_val;
            end else begin
                sdata    <= 1'b0;
                sdata_oe <= 1'b0;
            end
        end
    end

    // R12: line released while powered down
    assert_idle_hiz_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sdata_oe);

    // R13: no change of the line between launch edges
    assert_oe_on_launch_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !launch_evt) |=> ($stable(sdata_oe) && $stable(sdata)));

    // R11: a too-short frame never drives
    assert_invalid_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_evt && cfg_invalid) |=> !sdata_oe);

    // R5: a released line carries a zero data bit
    assert_quiet_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata);

endmodule

// File: tb/rj_tdm_tx_bench.sv
module rj_tdm_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n, en, bclk, wclk;
    logic [1:0]  cfg_wlen;
    logic [7:0]  cfg_offset;
    logic        cfg_bclk_inv, cfg_tristate;
    logic [31:0] smp_left, smp_right;
    logic        smp_valid;
    logic        smp_ready, sdata, sdata_oe, cfg_invalid;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    int  m_w;
    int  m_off;
    bit  m_tri;
    bit  m_dark;
    logic [31:0] cur_l, cur_r, pend_l, pend_r;
    bit  pend_ok;

    always #10 clk = ~clk;

    rj_tdm_tx u_rj_tdm_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .bclk         (bclk),
        .wclk         (wclk),
        .cfg_wlen     (cfg_wlen),
        .cfg_offset   (cfg_offset),
        .cfg_bclk_inv (cfg_bclk_inv),
        .cfg_tristate (cfg_tristate),
        .smp_left     (smp_left),
        .smp_right    (smp_right),
        .smp_valid    (smp_valid),
        .smp_ready    (smp_ready),
        .sdata        (sdata),
        .sdata_oe     (sdata_oe),
        .cfg_invalid  (cfg_invalid)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bits_of(input logic [1:0] code);
        case (code)
            2'd0: return 16;
            2'd1: return 20;
            2'd2: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic set_cfg(input logic [1:0] code, input int off, input bit tri_en);
        @(negedge clk);
        cfg_wlen     = code;
        cfg_offset   = off[7:0];
        cfg_tristate = tri_en;
        m_w   = bits_of(code);
        m_off = off;
        m_tri = tri_en;
    endtask

    // one bit clock: launch phase, check, capture phase, hold check
    task automatic bit_period(input logic lvl, input bit do_chk, input logic ed, input logic eo, input string req);
        logic d0, o0;
        @(negedge clk);
        bclk = cfg_bclk_inv ? 1'b1 : 1'b0;
        wclk = lvl;
        repeat (4) @(negedge clk);
        d0 = sdata;
        o0 = sdata_oe;
        if (do_chk) begin
            chk(req, "oe", {31'b0, o0}, {31'b0, eo});
            chk(req, "data", {31'b0, d0}, {31'b0, ed});
        end
        bclk = ~bclk;
        repeat (4) @(negedge clk);
        if (do_chk)
            chk("R13", "hold", {30'b0, sdata_oe, sdata}, {30'b0, o0, d0});
    endtask

    task automatic load(input logic [31:0] l, input logic [31:0] r, input string req);
        @(negedge clk);
        chk(req, "ready_before", {31'b0, smp_ready}, 32'd1);
        smp_left  = l;
        smp_right = r;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R10", "ready_after", {31'b0, smp_ready}, 32'd0);
        pend_l  = l;
        pend_r  = r;
        pend_ok = 1'b1;
    endtask

    task automatic load_mid(input logic [31:0] l, input logic [31:0] r);
        load(l, r, "R9");
        smp_left  = 32'hDEAD_0BAD;
        smp_right = 32'h0BAD_DEAD;
        smp_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "ready_while_full", {31'b0, smp_ready}, 32'd0);
        smp_valid = 1'b0;
    endtask

    task automatic run_frame(input int h, input bit do_chk, input string req,
                             input bit mid, input logic [31:0] ml, input logic [31:0] mr);
        for (int half = 0; half < 2; half++) begin
            for (int k = 0; k < h; k++) begin
                logic lvl, ed, eo;
                logic [31:0] word;
                int  b;
                bit  vld, bad;
                lvl = (half == 0);
                if (half == 0 && k == 0 && pend_ok) begin
                    cur_l   = pend_l;
                    cur_r   = pend_r;
                    pend_ok = 1'b0;
                end
                word = lvl ? cur_l : cur_r;
                b    = h - 1 - m_off - k;
                vld  = (b >= 0) && (b < m_w);
                bad  = (h < m_w) || m_dark;
                eo   = bad ? 1'b0 : (m_tri ? vld : 1'b1);
                ed   = (vld && !bad) ? word[b] : 1'b0;
                bit_period(lvl, do_chk, ed, eo, req);
                if (do_chk && !m_dark)
                    chk("R11", "invalid_flag", {31'b0, cfg_invalid}, {31'b0, (h < m_w)});
                if (mid && half == 0 && k == h / 2)
                    load_mid(ml, mr);
            end
        end
    endtask

    task automatic t_reset;
        chk("R1", "oe", {31'b0, sdata_oe}, 32'd0);
        chk("R1", "data", {31'b0, sdata}, 32'd0);
        chk("R1", "ready", {31'b0, smp_ready}, 32'd1);
        chk("R1", "invalid", {31'b0, cfg_invalid}, 32'd0);
    endtask

    task automatic t_basic;
        set_cfg(2'd0, 0, 1'b1);
        @(negedge clk);
        en = 1'b1;
        run_frame(16, 1'b0, "warm", 1'b0, 32'h0, 32'h0);
        load(32'h0000_A5C3, 32'h0000_3C96, "R3");
        run_frame(16, 1'b1, "R3", 1'b0, 32'h0, 32'h0);
        load(32'hFFFF_8001, 32'h1234_7FFE, "R4");
        run_frame(16, 1'b1, "R4", 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_wide;
        set_cfg(2'd2, 0, 1'b1);
        run_frame(32, 1'b0, "warm", 1'b0, 32'h0, 32'h0);
        load(32'h00C3_5A81, 32'h0081_7EE7, "R5");
        run_frame(32, 1'b1, "R5", 1'b0, 32'h0, 32'h0);
        set_cfg(2'd3, 4, 1'b1);
        load(32'hF0E1_D2C3, 32'h8765_4321, "R2");
        run_frame(32, 1'b1, "R2", 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_offset;
        set_cfg(2'd1, 5, 1'b1);
        load(32'h000A_B5E7, 32'h0005_4A18, "R6");
        run_frame(32, 1'b1, "R6", 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_drive_all;
        set_cfg(2'd1, 3, 1'b0);
        load(32'h000F_0F0F, 32'h000C_3C3C, "R7");
        run_frame(32, 1'b1, "R7", 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_midload;
        set_cfg(2'd2, 0, 1'b1);
        load(32'h0011_2233, 32'h0044_5566, "R9");
        run_frame(32, 1'b1, "R9", 1'b1, 32'h00AA_BBCC, 32'h00DD_EE99);
        run_frame(32, 1'b1, "R9", 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_invalid;
        set_cfg(2'd0, 0, 1'b1);
        run_frame(12, 1'b0, "warm", 1'b0, 32'h0, 32'h0);
        run_frame(12, 1'b1, "R11", 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_powerdown_inv;
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12", "oe_off", {31'b0, sdata_oe}, 32'd0);
        m_dark = 1'b1;
        run_frame(16, 1'b1, "R12", 1'b0, 32'h0, 32'h0);
        chk("R12", "invalid_off", {31'b0, cfg_invalid}, 32'd0);
        m_dark = 1'b0;
        cfg_bclk_inv = 1'b1;
        bclk = 1'b0;
        repeat (4) @(negedge clk);
        set_cfg(2'd0, 0, 1'b1);
        en = 1'b1;
        run_frame(16, 1'b0, "warm", 1'b0, 32'h0, 32'h0);
        load(32'h0000_9C35, 32'h0000_63CA, "R8");
        run_frame(16, 1'b1, "R8", 1'b0, 32'h0, 32'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; bclk = 1'b1; wclk = 1'b0;
        cfg_wlen = 2'd0; cfg_offset = 8'd0; cfg_bclk_inv = 1'b0; cfg_tristate = 1'b1;
        smp_left = '0; smp_right = '0; smp_valid = 1'b0;
        m_w = 16; m_off = 0; m_tri = 1'b1; m_dark = 1'b0;
        cur_l = '0; cur_r = '0; pend_l = '0; pend_r = '0; pend_ok = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_wide();
        t_offset();
        t_drive_all();
        t_midload();
        t_invalid();
        t_powerdown_inv();
        finish_run();
    end

endmodule